// File: doc/BRIEF.md
# Multiprocessor Masked Interrupt Controller

This controller gathers the device interrupt lines of a small multiprocessor system and turns them into a 4-bit processor interrupt level (PIL) for each processor. A global section samples the device lines into a pending register and gates them with a mask register. A set bit in the mask blocks its source. Software changes the mask through two write-only ports. One sets the bits written as one. The other clears the bits written as one.

Each unmasked source belongs to one fixed level, and several sources share most levels. A target register steers every device level to exactly one processor. Each processor also has a soft-interrupt register, set and cleared in the same write-one style, so that processors can interrupt one another. Each processor's output level is the highest level among its soft bits and, when it is the target, the unmasked device levels.

Access is through a single-cycle register port. Writes take effect at the clock edge. Reads are combinational.

Top module: `mpirq_ctrl`

## Requirements
- R1: After reset all 32 global mask bits are 1, the target register is 0, all soft bits are 0 and every processor level output is 0.
- R2: A write to the mask-set port (word 2) sets the mask bits written as one and leaves every other mask bit unchanged. The mask reads back at word 1.
- R3: A write to the mask-clear port (word 3) clears the mask bits written as one and leaves every other mask bit unchanged.
- R4: The pending register (word 0, read-only) shows the raw device lines, bits 30..0, one clock after they are sampled and regardless of the mask. Bit 31 always reads 0.
- R5: Mask bit 31 blocks every device source. Soft levels are still delivered while it is set.
- R6: Source bits map to fixed levels:
  - bits 30..27 map to level 15; bit 22 to 11; bit 21 to 9; bit 20 to 8; bit 19 to 10; bit 18 to 4; bit 17 to 13; bit 16 to 6; bits 15 and 14 to 12;
  - bits 7+n and n (n = 0..6) map to levels 2, 3, 5, 7, 9, 11 and 13 for n = 0..6.
- R7: Device levels reach only the processor whose index is in the target register (word 4, read/write, low bits).
- R8: Processor c has a status word at 8+4c, a set port at 10+4c and a clear port at 11+4c. On the set and clear ports, bit 16+n sets or clears soft level n (n = 1..15). Written bits 16..0 have no effect.
- R9: Each processor's level output is the highest of its soft levels and its delivered device levels, and is 0 when none is active.
- R10: Processor status word: bits 31..17 hold soft levels 15..1, and bit n (n = 1..15) is 1 when device level n is active for that processor. Bits 16 and 0 read 0.
- R11: Source bits 26..23 never raise any level, even when pending and unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_irq | input | 32 | Level-sensitive device interrupt lines |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | AW | Word index of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| cpu_pil | output | 4*NCPU | Interrupt level for each processor, processor c in bits 4c+3..4c |

## Verification
Every cycle, the assertions check the following:
- the mask after reset;
- that mask-set and mask-clear writes leave the unwritten bits unchanged;
- that mask bit 31 and the target register keep device levels away from the processors;
- that each level output is the highest active request.

The bench's scenarios are needed for the rest:
- the fixed source-to-level map, swept one source bit at a time;
- the pending readback;
- the inertness of bits 26..23 and of the low bits on the soft ports;
- the status word layout.

A cycle-level model in the bench also compares every processor level on every clock.

// File: rtl/mpirq_pkg.sv
package mpirq_pkg;
    localparam int DW       = 32;
    localparam int LW       = 4;
    localparam int NLVL     = 16;
    localparam int ALL_BIT  = 31;
    localparam int CPU_BASE = 8;
    localparam int CPU_STEP = 4;

    typedef enum logic [2:0] {
        G_PEND = 3'd0,
        G_MASK = 3'd1,
        G_MSET = 3'd2,
        G_MCLR = 3'd3,
        G_TGT  = 3'd4
    } greg_e;

    typedef enum logic [1:0] {
        C_STAT = 2'd0,
        C_SET  = 2'd2,
        C_CLR  = 2'd3
    } creg_e;

    typedef logic [LW-1:0] pil_t;

    function automatic pil_t src_level(input int b);
        int n;
        if (b >= 27 && b <= 30) return pil_t'(15);
        case (b)
            22: return pil_t'(11);
            21: return pil_t'(9);
            20: return pil_t'(8);
            19: return pil_t'(10);
            18: return pil_t'(4);
            17: return pil_t'(13);
            16: return pil_t'(6);
            15, 14: return pil_t'(12);
            default: begin
                if (b > 13 || b < 0) return pil_t'(0);
                n = (b >= 7) ? b - 7 : b;
                return (n == 0) ? pil_t'(2) : pil_t'(2 * n + 1);
            end
        endcase
    endfunction
endpackage

// File: rtl/mpirq_prio_enc.sv
module mpirq_prio_enc #(
    parameter int N  = 16,
    parameter int LW = 4
) (
    input  logic [N-1:0]  req,
    output logic [LW-1:0] lvl
);
    always_comb begin
        lvl = '0;
        for (int i = 1; i < N; i++) begin
            if (req[i]) lvl = LW'(i);
        end
    end
endmodule

// File: rtl/mpirq_global.sv
module mpirq_global
    import mpirq_pkg::*;
#(
    parameter int TW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] dev_irq,
    input  logic          mset_we,
    input  logic          mclr_we,
    input  logic          tgt_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] pend_q,
    output logic [DW-1:0] mask_q,
    output logic [TW-1:0] target_q,
    output logic [NLVL-1:0] dev_lvl
);
    logic [DW-1:0] set_bits, clr_bits;

    assign set_bits = mset_we ? wdata : '0;
    assign clr_bits = mclr_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= '0;
            mask_q   <= '1;
            target_q <= '0;
        end else begin
            pend_q   <= dev_irq & ~(DW'(1) << ALL_BIT);
            mask_q   <= (mask_q | set_bits) & ~clr_bits;
            if (tgt_we) target_q <= wdata[TW-1:0];
        end
    end

    always_comb begin
        dev_lvl = '0;
        for (int i = 0; i < ALL_BIT; i++) begin
            if (pend_q[i] && !mask_q[i] && !mask_q[ALL_BIT])
                dev_lvl[src_level(i)] = 1'b1;
        end
        dev_lvl[0] = 1'b0;
    end

    a_r1_reset_mask: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == '1));

    a_r2_set_keeps: assert property (@(posedge clk) disable iff (rst)
        (mset_we && !mclr_we) |=>
        ((mask_q & ~$past(wdata)) == ($past(mask_q) & ~$past(wdata))) &&
        ((mask_q & $past(wdata)) == $past(wdata)));

    a_r3_clr_keeps: assert property (@(posedge clk) disable iff (rst)
        (mclr_we && !mset_we) |=>
        ((mask_q & ~$past(wdata)) == ($past(mask_q) & ~$past(wdata))) &&
        ((mask_q & $past(wdata)) == '0));
endmodule

// File: rtl/mpirq_cpu.sv
module mpirq_cpu
    import mpirq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            set_we,
    input  logic            clr_we,
    input  logic [15:0]     wdata_hi,
    input  logic            is_target,
    input  logic [NLVL-1:0] dev_lvl,
    output logic [DW-1:0]   stat,
    output logic [LW-1:0]   pil
);
    logic [NLVL-1:0] soft_q, soft_nxt, hard, req;

    always_comb begin
        soft_nxt = soft_q;
        if (set_we) soft_nxt = soft_nxt | wdata_hi;
        if (clr_we) soft_nxt = soft_nxt & ~wdata_hi;
        soft_nxt[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) soft_q <= '0;
        else     soft_q <= soft_nxt;
    end

    assign hard = is_target ? dev_lvl : '0;
    assign req  = soft_q | hard;
    assign stat = {soft_q[15:1], 1'b0, hard};

    mpirq_prio_enc #(.N(NLVL), .LW(LW)) u_enc (
        .req (req),
        .lvl (pil)
    );

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (req == '0) |-> (pil == '0));

    a_r9_highest: assert property (@(posedge clk) disable iff (rst)
        (req != '0) |-> ((req >> pil) == NLVL'(1)));

    a_r1_soft_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stat[31:16] == '0));
endmodule

// File: rtl/mpirq_ctrl.sv
module mpirq_ctrl
    import mpirq_pkg::*;
#(
    parameter int NCPU = 4,
    parameter int AW   = $clog2(CPU_BASE + CPU_STEP * NCPU)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [31:0]        dev_irq,
    input  logic               reg_wr,
    input  logic [AW-1:0]      reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic [4*NCPU-1:0]  cpu_pil
);
    localparam int TW = (NCPU > 1) ? $clog2(NCPU) : 1;

    logic [DW-1:0]   pend_q, mask_q;
    logic [TW-1:0]   target_q;
    logic [NLVL-1:0] dev_lvl;
    logic [DW-1:0]   cpu_stat [NCPU];

    mpirq_global #(.TW(TW)) u_glob (
        .clk      (clk),
        .rst      (rst),
        .dev_irq  (dev_irq),
        .mset_we  (reg_wr && reg_addr == AW'(G_MSET)),
        .mclr_we  (reg_wr && reg_addr == AW'(G_MCLR)),
        .tgt_we   (reg_wr && reg_addr == AW'(G_TGT)),
        .wdata    (reg_wdata),
        .pend_q   (pend_q),
        .mask_q   (mask_q),
        .target_q (target_q),
        .dev_lvl  (dev_lvl)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic [LW-1:0] pil_c;

        mpirq_cpu u_cpu (
            .clk       (clk),
            .rst       (rst),
            .set_we    (reg_wr && reg_addr == AW'(CPU_BASE + CPU_STEP * c + int'(C_SET))),
            .clr_we    (reg_wr && reg_addr == AW'(CPU_BASE + CPU_STEP * c + int'(C_CLR))),
            .wdata_hi  (reg_wdata[31:16]),
            .is_target (target_q == TW'(c)),
            .dev_lvl   (dev_lvl),
            .stat      (cpu_stat[c]),
            .pil       (pil_c)
        );

        assign cpu_pil[c*LW +: LW] = pil_c;

        a_r7_target_only: assert property (@(posedge clk) disable iff (rst)
            (target_q != TW'(c)) |-> (cpu_stat[c][15:0] == '0));

        a_r5_mask_all: assert property (@(posedge clk) disable iff (rst)
            mask_q[ALL_BIT] |-> (cpu_stat[c][15:0] == '0));
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            AW'(G_PEND): reg_rdata = pend_q;
            AW'(G_MASK): reg_rdata = mask_q;
            AW'(G_TGT):  reg_rdata = DW'(target_q);
            default: begin
                for (int c = 0; c < NCPU; c++) begin
                    if (reg_addr == AW'(CPU_BASE + CPU_STEP * c + int'(C_STAT)))
                        reg_rdata = cpu_stat[c];
                end
            end
        endcase
    end
endmodule

// File: tb/mpirq_ctrl_bench.sv
module mpirq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCPU = 4;
    localparam int AW = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [31:0]       dev_irq = '0;
    logic              reg_wr = 1'b0;
    logic [AW-1:0]     reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [4*NCPU-1:0] cpu_pil;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    mpirq_ctrl #(.NCPU(NCPU)) u_mpirq_ctrl (
        .clk(clk), .rst(rst), .dev_irq(dev_irq), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_pil(cpu_pil)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference state
    logic [31:0] m_mask, m_pend;
    int          m_tgt;
    logic [15:0] m_soft [NCPU];

    function automatic int lvl_of(input int b);
        case (b)
            0, 7:   return 2;
            1, 8:   return 3;
            2, 9:   return 5;
            3, 10:  return 7;
            4, 11:  return 9;
            5, 12:  return 11;
            6, 13:  return 13;
            14, 15: return 12;
            16: return 6;
            17: return 13;
            18: return 4;
            19: return 10;
            20: return 8;
            21: return 9;
            22: return 11;
            27, 28, 29, 30: return 15;
            default: return 0;
        endcase
    endfunction

    function automatic logic [15:0] exp_hard(input int c);
        logic [15:0] h = '0;
        if (c == m_tgt && !m_mask[31])
            for (int i = 0; i < 31; i++)
                if (m_pend[i] && !m_mask[i]) h[lvl_of(i)] = 1'b1;
        h[0] = 1'b0;
        return h;
    endfunction

    function automatic int exp_pil(input int c);
        logic [15:0] r = m_soft[c] | exp_hard(c);
        int p = 0;
        for (int i = 1; i < 16; i++) if (r[i]) p = i;
        return p;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mask = '1; m_pend = '0; m_tgt = 0;
            for (int c = 0; c < NCPU; c++) m_soft[c] = '0;
        end else begin
            m_pend = dev_irq & 32'h7FFF_FFFF;
            if (reg_wr) begin
                if (reg_addr == 2) m_mask = m_mask | reg_wdata;
                if (reg_addr == 3) m_mask = m_mask & ~reg_wdata;
                if (reg_addr == 4) m_tgt = int'(reg_wdata[1:0]);
                for (int c = 0; c < NCPU; c++) begin
                    if (reg_addr == AW'(10 + 4*c)) m_soft[c] = m_soft[c] | reg_wdata[31:16];
                    if (reg_addr == AW'(11 + 4*c)) m_soft[c] = m_soft[c] & ~reg_wdata[31:16];
                    m_soft[c][0] = 1'b0;
                end
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R9: per-cycle comparison of every level output against the model
    always @(negedge clk) begin
        if (!rst && !done)
            for (int c = 0; c < NCPU; c++)
                check("R9 model pil", 32'(cpu_pil[c*4 +: 4]), 32'(exp_pil(c)));
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input int a, input logic [31:0] exp);
        reg_addr = AW'(a);
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic drive(input logic [31:0] v);
        @(negedge clk);
        dev_irq = v;
        @(negedge clk);
    endtask

    function automatic logic [3:0] pil(input int c);
        return cpu_pil[c*4 +: 4];
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd("R1 mask reset", 1, 32'hFFFF_FFFF);
        rd("R1 target reset", 4, 0);
        rd("R1 soft reset", 8, 0);
        check("R1 pil reset", 32'(cpu_pil), 0);

        // initialization sequence
        wr(2, 32'h7FFF_FFFF);
        rd("R2 set keeps", 1, 32'hFFFF_FFFF);
        for (int c = 0; c < NCPU; c++) wr(11 + 4*c, ~32'h17fff);
        wr(3, 32'h8000_0000);
        rd("R3 clear bit31", 1, 32'h7FFF_FFFF);

        // R4 pending raw, masked source silent
        drive(32'h0004_0000);
        rd("R4 pending raw", 0, 32'h0004_0000);
        check("R4 masked silent", 32'(pil(0)), 0);

        wr(3, 32'h0004_0000);
        rd("R3 clear one bit", 1, 32'h7FFB_FFFF);
        check("R6 scsi level", 32'(pil(0)), 4);
        check("R7 non-target", 32'(pil(1)), 0);

        wr(4, 2);
        rd("R7 target read", 4, 2);
        check("R7 steered", 32'(pil(2)), 4);
        check("R7 old target off", 32'(pil(0)), 0);

        dev_irq = 32'h0005_0000;
        wr(3, 32'h0001_0000);
        check("R9 highest device", 32'(pil(2)), 6);

        wr(18, 32'h0200_0000);
        wr(14, 32'h0008_0000);
        check("R9 soft above dev", 32'(pil(2)), 9);
        check("R8 soft level 3", 32'(pil(1)), 3);
        rd("R10 status word", 16, 32'h0200_0050);

        wr(2, 32'h8000_0000);
        rd("R5 mask all hard", 16, 32'h0200_0000);
        check("R5 soft still", 32'(pil(2)), 9);
        wr(3, 32'h8000_0000);

        wr(2, 32'h0001_0000);
        rd("R2 set one bit", 1, 32'h7FFB_FFFF);
        rd("R10 status after set", 16, 32'h0200_0010);

        dev_irq = 32'h4005_0000;
        wr(3, 32'h4000_0000);
        check("R6 error level", 32'(pil(2)), 15);

        dev_irq = 32'h4105_0000;
        wr(3, 32'h0100_0000);
        rd("R11 unused bit", 16, 32'h0200_8010);
        rd("R4 pending multi", 0, 32'h4105_0000);

        wr(10, 32'h0001_0020);
        rd("R8 low bits ignored", 8, 0);
        check("R8 pil idle", 32'(pil(0)), 0);

        wr(19, 32'h0200_0000);
        check("R8 soft cleared", 32'(pil(2)), 15);

        // R6 sweep of every source bit, one at a time
        wr(3, 32'hFFFF_FFFF);
        wr(4, 0);
        wr(15, 32'hFFFF_0000);
        for (int i = 0; i < 31; i++) begin
            drive(32'(1) << i);
            check($sformatf("R6 bit %0d", i), 32'(pil(0)), 32'(lvl_of(i)));
        end
        drive(32'h8000_0000);
        rd("R4 bit31 zero", 0, 0);
        check("R11 bit31 no level", 32'(pil(0)), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule